// File: doc/BRIEF.md
# Eight-Function 32-bit ALU

This block is a purely combinational arithmetic and logic unit for a simple processor datapath. It takes two operands and a 3-bit operation code and returns a result word together with three flags: Zero, CarryOut and Overflow. It supports add, subtract, four bitwise functions, a signed comparison and an unsigned comparison. A single shared adder handles addition, subtraction and both comparisons.

The surrounding datapath uses the block in three ways:
- It adds a base register and an offset to form load and store addresses.
- It subtracts two registers and reads Zero to decide equality branches and conditional moves.
- It uses the signed comparison to test a register against zero. For a below-zero test, the register goes on A and zero goes on B. For an above-zero test, zero goes on A and the register goes on B.

Shifting, immediate extension and operand selection are handled outside the block.

Top module: `alu8_core`

## Requirements
- R1: The op_sel encodings are 000 AND, 001 OR, 010 ADD, 011 SLTU, 100 XOR, 101 NOR, 110 SUB and 111 SLT. The four logic codes return the bitwise AND, OR, XOR and NOR of the operands.
- R2: ADD returns (A+B) mod 2^32. carry_out is the carry out of bit 31.
- R3: SUB returns (A-B) mod 2^32. carry_out is 1 exactly when A < B as unsigned numbers, which is a borrow.
- R4: For ADD and SUB, overflow is 1 exactly when the two's-complement result does not fit in 32 bits. For every other code, overflow is 0.
- R5: SLT returns 32'd1 when A < B as two's-complement numbers and 32'd0 otherwise. This holds even when A-B overflows, so it can serve the below-zero and above-zero register tests.
- R6: SLTU returns 32'd1 exactly when carry_out for SUB on the same operands would be 1, and 32'd0 otherwise.
- R7: zero is 1 exactly when all 32 bits of result are 0, for every operation code.
- R8: For the four logic codes, carry_out is 0.
- R9: For SLT and SLTU, carry_out is the subtraction borrow, meaning A < B as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| carry_out | output | 1 | Adder carry (ADD) or borrow (SUB, SLT, SLTU) |
| overflow | output | 1 | Signed overflow of ADD or SUB |

## Verification
Assertions check the following on every input change:
- A comparison result never has a bit set above bit 0.
- The SLTU result bit agrees with the borrow flag from the shared adder.
- Overflow stays low outside ADD and SUB.
- The carry flag stays low for the logic codes.
- Subtracting equal operands raises zero.

Whether the arithmetic values themselves are right can only be shown by the bench's scenarios. These include the wrap-around at 0xFFFFFFFF and signed overflow at 0x7FFFFFFF and 0x80000000. They also include SLT across an overflowing difference and the two zero-test operand placements. A model-driven sweep over pseudo-random operands completes the picture.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_SLTU = 3'b011,
    OP_XOR  = 3'b100,
    OP_NOR  = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff = subtract ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
    sum   = wide[WIDTH-1:0];
    carry = wide[WIDTH];
    // signs of both adder inputs agree but the sum sign differs
    ovf   = ~(a[MSB] ^ b_eff[MSB]) & (a[MSB] ^ sum[MSB]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       fn,
  output logic [WIDTH-1:0] y
);
  // fn: 00 and, 01 or, 10 xor, 11 nor
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (fn)
        2'b00:   y[i] = a[i] & b[i];
        2'b01:   y[i] = a[i] | b[i];
        2'b10:   y[i] = a[i] ^ b[i];
        default: y[i] = ~(a[i] | b[i]);
      endcase
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  logic    do_sub;
  logic    is_arith;
  logic    is_cmp;
  logic    borrow;
  logic    lt_signed;

  logic [WIDTH-1:0] as_sum;
  logic             as_carry;
  logic             as_ovf;
  logic [WIDTH-1:0] lg_y;

  assign op       = alu_op_e'(op_sel);
  assign do_sub   = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign is_cmp   = (op == OP_SLT) || (op == OP_SLTU);

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a        (opnd_a),
    .b        (opnd_b),
    .subtract (do_sub),
    .sum      (as_sum),
    .carry    (as_carry),
    .ovf      (as_ovf)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .fn ({op_sel[2], op_sel[0]}),
    .y  (lg_y)
  );

  assign borrow    = ~as_carry;
  assign lt_signed = as_sum[MSB] ^ as_ovf;

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = as_sum;
      OP_SLT:         result = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU:        result = {{(WIDTH-1){1'b0}}, borrow};
      default:        result = lg_y;
    endcase
  end

  assign zero      = ~|result;
  assign carry_out = (op == OP_ADD) ? as_carry : (do_sub ? borrow : 1'b0);
  assign overflow  = is_arith & as_ovf;

  always_comb begin
    if (is_cmp) begin
      AST_CMP_BOOLEAN: assert (result[WIDTH-1:1] == '0); // R5
    end
    if (op == OP_SLTU) begin
      AST_SLTU_BORROW: assert (result[0] == carry_out); // R6
    end
    if (!is_arith) begin
      AST_NO_OVERFLOW: assert (!overflow); // R4
    end
    if (!is_arith && !is_cmp) begin
      AST_LOGIC_NO_CARRY: assert (!carry_out); // R8
    end
    if (op == OP_SUB && opnd_a == opnd_b) begin
      AST_EQUAL_ZERO: assert (zero && !carry_out); // R7
    end
  end
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  localparam int W = 32;
  localparam int NVEC = 16;
  localparam int WATCHDOG = 100000;

  logic clk;
  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] res;
  logic         z, c, v;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  alu8_core #(.WIDTH(W)) u0 (
    .opnd_a(a), .opnd_b(b), .op_sel(op),
    .result(res), .zero(z), .carry_out(c), .overflow(v)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // {op, a, b, result, zero, carry, overflow}
  localparam logic [101:0] VECS [NVEC] = '{
    {3'b000, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h00F0_F000, 1'b0, 1'b0, 1'b0},
    {3'b001, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'hFFF0_FFF0, 1'b0, 1'b0, 1'b0},
    {3'b100, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'hFF00_0FF0, 1'b0, 1'b0, 1'b0},
    {3'b101, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h000F_000F, 1'b0, 1'b0, 1'b0},
    {3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1, 1'b0},
    {3'b010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
    {3'b110, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0, 1'b1, 1'b0},
    {3'b110, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    {3'b110, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1},
    {3'b111, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    {3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1, 1'b0},
    {3'b111, 32'h0000_0000, 32'h0000_0005, 32'h0000_0001, 1'b0, 1'b1, 1'b0},
    {3'b111, 32'hFFFF_FFF0, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    {3'b011, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0},
    {3'b011, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    {3'b010, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b1}
  };

  localparam string TAGS [NVEC] = '{
    "R1 R8 and", "R1 R8 or", "R1 R8 xor", "R1 R8 nor",
    "R2 R7 add wrap", "R4 add ovf", "R3 sub borrow", "R3 R7 sub equal",
    "R4 sub ovf", "R5 R9 slt ovf diff", "R5 R9 slt max vs -1", "R5 above-zero test",
    "R5 below-zero test", "R6 R9 sltu true", "R6 R7 sltu false", "R2 R4 add both"
  };

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'b010:  return "R2 R4 add";
      3'b110:  return "R3 R4 sub";
      3'b111:  return "R5 R9 slt";
      3'b011:  return "R6 R9 sltu";
      default: return "R1 R8 logic";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] er,
                       input logic ez, input logic ec, input logic ev);
    n_tests++;
    if (res !== er || z !== ez || c !== ec || v !== ev) begin
      n_fail++;
      $display("FAIL %s: actual res=%h z=%b c=%b v=%b expected res=%h z=%b c=%b v=%b",
               tag, res, z, c, v, er, ez, ec, ev);
    end
  endtask

  task automatic model_check(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0]   t;
    logic [W-1:0] er;
    logic         ec, ev;
    ec = 0; ev = 0;
    case (o)
      3'b000: er = x & y;
      3'b001: er = x | y;
      3'b100: er = x ^ y;
      3'b101: er = ~(x | y);
      3'b010: begin
        t = {1'b0, x} + {1'b0, y}; er = t[W-1:0]; ec = t[W];
        ev = (x[W-1] == y[W-1]) && (er[W-1] != x[W-1]);
      end
      3'b110: begin
        er = x - y; ec = (x < y);
        ev = (x[W-1] != y[W-1]) && (er[W-1] != x[W-1]);
      end
      3'b111: begin er = ($signed(x) < $signed(y)) ? 1 : 0; ec = (x < y); end
      default: begin er = (x < y) ? 1 : 0; ec = (x < y); end
    endcase
    op = o; a = x; b = y;
    #1;
    check(op_tag(o), er, (er == 0), ec, ev);
  endtask

  initial begin
    logic [W-1:0] lf;
    a = '0; b = '0; op = 3'b000;
    #1;
    check("R1 R7 idle all-zero inputs", 32'h0, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      op = VECS[i][101:99];
      a  = VECS[i][98:67];
      b  = VECS[i][66:35];
      #1;
      check(TAGS[i], VECS[i][34:3], VECS[i][2], VECS[i][1], VECS[i][0]);
      #1;
    end

    // directed corners: sign boundary comparisons
    model_check(3'b111, 32'h8000_0000, 32'h7FFF_FFFF); // R5
    model_check(3'b011, 32'h8000_0000, 32'h7FFF_FFFF); // R6
    model_check(3'b110, 32'h0000_0000, 32'h8000_0000); // R4
    model_check(3'b111, 32'h0000_0000, 32'h0000_0000); // R5 R7

    // pseudo-random sweep over every code
    lf = 32'hACE1_2468;
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] x, y;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      x = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      y = (k % 5 == 0) ? x : lf;
      for (int o = 0; o < 8; o++) model_check(3'(o), x, y);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule